// File: doc/BRIEF.md
# Masked Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt lines from board peripherals and turns them into a single 4-bit interrupt-level code for the processor. Every line owns one fixed bit in a 16-bit live status word, and a software-writable 16-bit enable mask selects which of those bits may reach the processor. Among the enabled sources that are asserted, the source with the smallest priority number wins. Its number is inverted, which is the same as XOR with 15, before it is driven out. When no source is eligible the output is therefore 0.

A small register window sits on a simple synchronous bus. The window holds the enable mask, a power-control register, a general-purpose output register and a fixed version register. The power-control and output registers also drive parallel output ports for the board.

Top module: `irl_agg`

## Requirements
- R1: Source line `src_irq[i]` has priority number i. Its status bit, by index i = 0..12, is 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0 and 15. A line held high sets its status bit, and a line held low clears it.
- R2: A source is eligible only when both its status bit and the same bit of the enable mask are 1. A source whose mask bit is 0 never affects `int_level`.
- R3: When several sources are eligible, the source with the smallest priority number sets the output.
- R4: `int_level` equals the winning priority number XOR 15. It is 0 when no source is eligible, and 15 when source 0 wins.
- R5: A change on `src_irq` or a write to the mask shows on `int_level` at the first rising edge after it, and does not show before that edge.
- R6: Byte offset 0x00 holds the enable mask. A write stores `bus_wdata` and a read returns the stored value.
- R7: Byte offset 0x30 holds the power-control register. It can be read and written, and its value drives `pwr_ctl` at all times.
- R8: Byte offset 0x36 holds the general-purpose output register. It can be read and written, and its value drives `gp_out` at all times.
- R9: Byte offset 0x32 always reads 0x0010. Writes to it change no register.
- R10: A read of any other offset returns 0. A write to any other offset changes no register.
- R11: Synchronous active-high reset clears the status, the mask, the power-control register and the output register to 0. `int_level` and `bus_rdata` read 0 after reset.
- R12: `bus_rdata` carries the read result in the cycle after a read strobe. It is 0 after a write strobe or after a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_irq | input | 13 | Interrupt lines, indexed by priority number |
| bus_vld | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| int_level | output | 4 | Encoded interrupt level, 0 when idle |
| pwr_ctl | output | 16 | Power-control register contents |
| gp_out | output | 16 | General-purpose output register contents |

## Verification
The assertions take for granted that the interrupt lines are already synchronous to `clk`. They also assume that every bus strobe lasts exactly one cycle, with the address and data stable around the rising edge. The mask-gating property further assumes that no write to the mask falls in the cycle it observes, so that cycle is excluded by its antecedent. The stimulus changes inputs only on falling edges and issues each access as a one-cycle strobe. Random offsets are drawn mostly from the four defined ones, with occasional arbitrary values so that the unmapped and odd offsets are also exercised.

// File: rtl/irl_agg_pkg.sv
package irl_agg_pkg;

    localparam int NUM_SRC  = 13;
    localparam int STAT_W   = 16;
    localparam int LVL_W    = 4;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 16;

    localparam logic [LVL_W-1:0]  LVL_IDLE   = '1;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_PWR    = 6'h30;
    localparam logic [ADDR_W-1:0] OFF_VER    = 6'h32;
    localparam logic [ADDR_W-1:0] OFF_GPO    = 6'h36;
    localparam logic [DATA_W-1:0] VER_VALUE  = 16'h0010;

    // status bit owned by the source of priority number idx
    function automatic int src_bit(input int idx);
        case (idx)
            0:  return 11;
            1:  return 9;
            2:  return 8;
            3:  return 12;
            4:  return 10;
            5:  return 6;
            6:  return 5;
            7:  return 4;
            8:  return 7;
            9:  return 14;
            10: return 13;
            11: return 0;
            default: return 15;
        endcase
    endfunction

    // priority number: sources are indexed in priority order
    function automatic int src_level(input int idx);
        return idx;
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] pwr;
        logic [DATA_W-1:0] gpo;
        logic [DATA_W-1:0] rdata;
    } regs_t;

endpackage

// File: rtl/irl_status_cap.sv
module irl_status_cap
    import irl_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int SW    = STAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_i,
    output logic [SW-1:0]    status_q_o
);

    logic [SW-1:0] status_d;
    logic [SW-1:0] status_q;

    always_comb begin
        status_d = '0;
        for (int i = 0; i < N_SRC; i++) begin
            status_d[src_bit(i)] = src_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_q_o = status_q;

endmodule

// File: rtl/irl_prio_enc.sv
module irl_prio_enc
    import irl_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int SW    = STAT_W,
    parameter int LW    = LVL_W
) (
    input  logic [SW-1:0] status_i,
    input  logic [SW-1:0] mask_i,
    output logic [LW-1:0] code_o
);

    localparam logic [LW-1:0] IDLE = '1;

    logic [N_SRC-1:0] elig;
    logic [LW-1:0]    win_lvl;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        localparam int BIT = src_bit(g);
        assign elig[g] = status_i[BIT] & mask_i[BIT];
    end

    always_comb begin
        win_lvl = IDLE;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (LW'(src_level(i)) < win_lvl)) begin
                win_lvl = LW'(src_level(i));
            end
        end
    end

    assign code_o = win_lvl ^ IDLE;

endmodule

// File: rtl/irl_regbank.sv
module irl_regbank
    import irl_agg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] mask_o,
    output logic [DW-1:0] pwr_o,
    output logic [DW-1:0] gpo_o,
    output logic [DW-1:0] rdata_o
);

    regs_t regs_d;
    regs_t regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.rdata = '0;
        if (vld_i && we_i) begin
            case (addr_i)
                OFF_MASK: regs_d.mask = wdata_i;
                OFF_PWR:  regs_d.pwr  = wdata_i;
                OFF_GPO:  regs_d.gpo  = wdata_i;
                default:  ;
            endcase
        end else if (vld_i) begin
            case (addr_i)
                OFF_MASK: regs_d.rdata = regs_q.mask;
                OFF_PWR:  regs_d.rdata = regs_q.pwr;
                OFF_VER:  regs_d.rdata = VER_VALUE;
                OFF_GPO:  regs_d.rdata = regs_q.gpo;
                default:  regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mask_o  = regs_q.mask;
    assign pwr_o   = regs_q.pwr;
    assign gpo_o   = regs_q.gpo;
    assign rdata_o = regs_q.rdata;

endmodule

// File: rtl/irl_agg.sv
module irl_agg
    import irl_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               bus_vld,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [LVL_W-1:0]   int_level,
    output logic [DATA_W-1:0]  pwr_ctl,
    output logic [DATA_W-1:0]  gp_out
);

    logic [STAT_W-1:0] status_q;
    logic [DATA_W-1:0] mask_q;

    irl_status_cap #(
        .N_SRC (NUM_SRC),
        .SW    (STAT_W)
    ) u_status (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_irq),
        .status_q_o (status_q)
    );

    irl_regbank #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (bus_vld),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .mask_o  (mask_q),
        .pwr_o   (pwr_ctl),
        .gpo_o   (gp_out),
        .rdata_o (bus_rdata)
    );

    // encoder reads only registered state, so the code follows inputs by one edge
    irl_prio_enc #(
        .N_SRC (NUM_SRC),
        .SW    (STAT_W),
        .LW    (LVL_W)
    ) u_enc (
        .status_i (status_q),
        .mask_i   (mask_q),
        .code_o   (int_level)
    );

endmodule

// File: rtl/irl_agg_chk.sv
module irl_agg_chk
    import irl_agg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_irq,
    input logic               bus_vld,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [LVL_W-1:0]   int_level,
    input logic [DATA_W-1:0]  pwr_ctl,
    input logic [DATA_W-1:0]  gp_out,
    input logic [DATA_W-1:0]  mask_q
);

    logic wr_mask;
    logic wr_pwr;
    logic wr_gpo;
    logic rd_ver;
    logic rd_unmapped;

    assign wr_mask = bus_vld && bus_we && (bus_addr == OFF_MASK);
    assign wr_pwr  = bus_vld && bus_we && (bus_addr == OFF_PWR);
    assign wr_gpo  = bus_vld && bus_we && (bus_addr == OFF_GPO);
    assign rd_ver  = bus_vld && !bus_we && (bus_addr == OFF_VER);
    assign rd_unmapped = bus_vld && !bus_we && (bus_addr != OFF_MASK) &&
                         (bus_addr != OFF_PWR) && (bus_addr != OFF_VER) &&
                         (bus_addr != OFF_GPO);

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (src_irq == '0) |=> (int_level == '0));

    assert_top_prio_R3: assert property (@(posedge clk) disable iff (rst)
        (src_irq[0] && mask_q[src_bit(0)] && !wr_mask) |=> (int_level == 4'hF));

    assert_masked_out_R2: assert property (@(posedge clk) disable iff (rst)
        ((src_irq[NUM_SRC-1:1] == '0) && !mask_q[src_bit(0)] && !wr_mask)
        |=> (int_level == '0));

    assert_version_R9: assert property (@(posedge clk) disable iff (rst)
        rd_ver |=> (bus_rdata == VER_VALUE));

    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
        rd_unmapped |=> (bus_rdata == '0));

    assert_pwr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_pwr |=> $stable(pwr_ctl));

    assert_gpo_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_gpo |=> $stable(gp_out));

    assert_no_strobe_rdata_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_vld |=> (bus_rdata == '0));

    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> ((int_level == '0) && (pwr_ctl == '0) && (gp_out == '0) &&
                 (bus_rdata == '0)));

endmodule

bind irl_agg irl_agg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_irq   (src_irq),
    .bus_vld   (bus_vld),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .int_level (int_level),
    .pwr_ctl   (pwr_ctl),
    .gp_out    (gp_out),
    .mask_q    (mask_q)
);

// File: tb/irl_agg_tb_top.sv
module irl_agg_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] src_irq = '0;
    logic        bus_vld = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  int_level;
    logic [15:0] pwr_ctl;
    logic [15:0] gp_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] m_mask = '0;
    logic [15:0] m_pwr  = '0;
    logic [15:0] m_gpo  = '0;

    always #5 clk = ~clk;

    irl_agg dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_irq   (src_irq),
        .bus_vld   (bus_vld),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .int_level (int_level),
        .pwr_ctl   (pwr_ctl),
        .gp_out    (gp_out)
    );

    function automatic int bit_of(input int i);
        int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return t[i];
    endfunction

    function automatic logic [3:0] exp_code(input logic [12:0] s, input logic [15:0] m);
        int lvl = 15;
        for (int i = 12; i >= 0; i--) begin
            if (s[i] && m[bit_of(i)]) lvl = i;
        end
        return 4'(lvl ^ 15);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus/input cycle, then compare every output against the model
    task automatic step(input logic [12:0] s, input logic v, input logic w,
                        input logic [5:0] a, input logic [15:0] d, input string tag);
        logic [15:0] exp_rd;
        @(negedge clk);
        src_irq = s; bus_vld = v; bus_we = w; bus_addr = a; bus_wdata = d;
        exp_rd = '0;
        if (v && !w) begin
            case (a)
                6'h00: exp_rd = m_mask;
                6'h30: exp_rd = m_pwr;
                6'h32: exp_rd = 16'h0010;
                6'h36: exp_rd = m_gpo;
                default: exp_rd = '0;
            endcase
        end
        if (v && w) begin
            case (a)
                6'h00: m_mask = d;
                6'h30: m_pwr  = d;
                6'h36: m_gpo  = d;
                default: ;
            endcase
        end
        @(posedge clk);
        #2;
        check({tag, " rdata R12"}, bus_rdata, exp_rd);
        check({tag, " level"}, {12'h0, int_level}, {12'h0, exp_code(s, m_mask)});
        check({tag, " pwr R7"}, pwr_ctl, m_pwr);
        check({tag, " gpo R8"}, gp_out, m_gpo);
    endtask

    task automatic idle(input logic [12:0] s, input string tag);
        step(s, 1'b0, 1'b0, 6'h00, 16'h0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        src_irq = 13'h1FFF;
        repeat (3) @(posedge clk);
        #2;
        check("R11 reset level", {12'h0, int_level}, 16'h0);
        check("R11 reset pwr", pwr_ctl, 16'h0);
        check("R11 reset gpo", gp_out, 16'h0);
        check("R11 reset rdata", bus_rdata, 16'h0);
        @(negedge clk);
        rst = 1'b0;
        // mask is zero after reset, so all sources masked
        idle(13'h1FFF, "R11 mask zero");
        step(13'h1FFF, 1'b1, 1'b0, 6'h00, 16'h0, "R11 read mask");

        // R6 mask write and read back
        step(13'h0, 1'b1, 1'b1, 6'h00, 16'hFFFF, "R6 write");
        step(13'h0, 1'b1, 1'b0, 6'h00, 16'h0, "R6 read");

        // R1 each source alone, R4 code = idx^15
        for (int i = 0; i < 13; i++) begin
            idle(13'(1 << i), "R1 single source R4");
        end
        idle(13'h0, "R4 idle");

        // R3 lowest priority number wins
        idle(13'b1_0000_0010_0100, "R3 pair");
        idle(13'h1FFE, "R3 all but 0");
        idle(13'h1FFF, "R3 all");

        // R2 mask gating: clear bit owned by source 0 (bit 11)
        step(13'h1, 1'b1, 1'b1, 6'h00, 16'hF7FF, "R2 clear bit11");
        idle(13'h1, "R2 masked source");
        idle(13'h3, "R2 next source wins");

        // R5: output must not move before the edge
        idle(13'h0, "R5 base");
        @(negedge clk);
        src_irq = 13'h1000;
        #2;
        check("R5 before edge", {12'h0, int_level}, 16'h0);
        @(posedge clk);
        #2;
        check("R5 after edge", {12'h0, int_level}, {12'h0, exp_code(13'h1000, m_mask)});

        // R7 R8 registers and ports
        step(13'h0, 1'b1, 1'b1, 6'h30, 16'hA5C3, "R7 write");
        step(13'h0, 1'b1, 1'b0, 6'h30, 16'h0, "R7 read");
        step(13'h0, 1'b1, 1'b1, 6'h36, 16'h3C5A, "R8 write");
        step(13'h0, 1'b1, 1'b0, 6'h36, 16'h0, "R8 read");

        // R9 version fixed, writes ignored
        step(13'h0, 1'b1, 1'b1, 6'h32, 16'hBEEF, "R9 write");
        step(13'h0, 1'b1, 1'b0, 6'h32, 16'h0, "R9 read");

        // R10 unmapped accesses
        step(13'h0, 1'b1, 1'b1, 6'h02, 16'h1234, "R10 write 02");
        step(13'h0, 1'b1, 1'b1, 6'h31, 16'h5678, "R10 write 31");
        step(13'h0, 1'b1, 1'b0, 6'h31, 16'h0, "R10 read 31");
        step(13'h0, 1'b1, 1'b0, 6'h3F, 16'h0, "R10 read 3F");
        step(13'h0, 1'b1, 1'b0, 6'h00, 16'h0, "R10 mask kept");

        // constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic [12:0] s;
            logic [5:0]  a;
            logic [2:0]  pick;
            pick = 3'($urandom_range(0, 7));
            case (pick)
                0, 1: a = 6'h00;
                2:    a = 6'h30;
                3:    a = 6'h32;
                4:    a = 6'h36;
                default: a = 6'($urandom);
            endcase
            s = ($urandom_range(0, 3) == 0) ? 13'($urandom) : 13'(1 << $urandom_range(0, 12));
            step(s, 1'($urandom), 1'($urandom), a, 16'($urandom), "rand R1 R2 R3");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule